// File: doc/BRIEF.md
# Secure-Aware Pin Bank Controller

This block controls one bank of sixteen I/O pins from a 32-bit register interface. Each pin has a software-chosen mode: general-purpose input, general-purpose output, alternate function or analog. Each pin also has a pull selection, a push-pull/open-drain choice, a two-bit slew code and a four-bit alternate-function select. From these settings the block drives the pad control lines of every pin. In alternate-function mode the selected peripheral line sets both the driven level and the direction.

Pad levels pass through a synchroniser before software can read them. A write-only set/clear register lets several agents change single output bits without a read-modify-write. Each pin has a secure bit. An access that is not secure cannot change a secure pin's settings and reads zero in that pin's positions.

Every access is one strobe. A write takes effect at the clock edge that samples the strobe. Read data is combinational from the address while a read strobe is high.

Top module: `secure_pin_bank`

## Requirements
- R1: During and after reset every pin is in analog mode (MODE reads 0xFFFFFFFF). Pad output enables are all 0, analog enables all 1, pulls all off, and every other setting is 0.
- R2: The word address map is: 0 MODE, 1 PULL, 2 OTYPE, 3 SPEED, 4 AFLO, 5 AFHI, 6 ODATA, 7 SETCLR, 8 IDATA, 9 SECMASK. Other addresses ignore writes and read 0.
- R2 (continued): A pin's mode is bits 2p+1:2p of MODE, coded 00 input, 01 output, 10 alternate function, 11 analog. In input mode the pin does not drive. In output mode with push-pull, output enable is 1 and the pad value is ODATA bit p.
- R3: PULL bits 2p+1:2p select 01 pull-up, 10 pull-down, 00 or 11 none, in input, output and alternate-function modes. In analog mode both pull enables are 0 whatever PULL holds.
- R4: AFLO bits 4p+3:4p select the function of pin p for pins 0–7, and AFHI bits 4(p-8)+3:4(p-8) for pins 8–15. In alternate-function mode, peripheral line af_val[16p+sel] sets the pad value and af_dir[16p+sel] sets the output enable. In any other mode the peripheral lines have no effect on the pad.
- R5: With OTYPE bit p = 1 (open-drain), in output and alternate-function modes the pad value is always 0. The output enable is 1 only when the pin is meant to drive 0 with direction out. Whenever the output enable is 0, pad_out is 0.
- R6: SPEED bits 2p+1:2p (00 lowest to 11 highest) reach pad_speed in output and alternate-function modes. In input and analog modes they read 00 at the pad.
- R7: A write to SETCLR sets ODATA bits where data bits 15:0 are 1 and clears bits where data bits 31:16 are 1. A pin named in both halves ends up set. SETCLR reads 0.
- R8: IDATA bit p shows pad_in[p] after exactly SYNC_STAGES (default 2) rising edges. It reads 0 while the pin is in analog mode.
- R9: A write with bus_sec = 0 leaves every field of a pin whose SECMASK bit is 1 unchanged, and updates the fields of the other pins normally.
- R10: A read with bus_sec = 0 returns 0 in all bit positions that belong to pins whose SECMASK bit is 1.
- R11: SECMASK resets to 0xFFFF, changes only on a write with bus_sec = 1, and reads back the same for every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 1 | Access is secure |
| bus_rdata | output | 32 | Read data, 0 when no read strobe |
| pad_in | input | 16 | Raw pad levels |
| pad_out | output | 16 | Pad drive value |
| pad_oe | output | 16 | Pad output enable |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pad_ana | output | 16 | Analog enable |
| pad_speed | output | 32 | Slew code, 2 bits per pin |
| af_val | input | 256 | Peripheral drive levels, 16 per pin |
| af_dir | input | 256 | Peripheral directions, 16 per pin |

## Verification
Pad outputs are first tried with directed settings. These include every pin in one mode at a time, a set/clear word that both sets and clears, and a set/clear word that names the same pin in both halves. They also include open-drain with mixed output bits, and a function-select pattern in which each pin picks a different line index, which separates a working mux from a wrong select or a swapped AFLO/AFHI. A split secure mask then shows that a non-secure write and a non-secure read act per pin and not per register. Random writes to any address follow, with random security, mask, peripheral lines and pad levels. After each one every pad output and a random read-back are compared with a bench model, which covers mixed-mode banks the directed cases do not reach.

// File: rtl/spb_pkg.sv
package spb_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int NPINS   = REG_W / 2;
    localparam int AF_W    = 4;
    localparam int AF_NUM  = 1 << AF_W;
    localparam int W2      = 2 * NPINS;
    localparam int W4      = AF_W * NPINS;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 4'd0,
        A_PULL   = 4'd1,
        A_OTYPE  = 4'd2,
        A_SPEED  = 4'd3,
        A_AFLO   = 4'd4,
        A_AFHI   = 4'd5,
        A_ODATA  = 4'd6,
        A_SETCLR = 4'd7,
        A_IDATA  = 4'd8,
        A_SECM   = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_IN  = 2'b00,
        M_OUT = 2'b01,
        M_AF  = 2'b10,
        M_ANA = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        P_NONE = 2'b00,
        P_UP   = 2'b01,
        P_DOWN = 2'b10,
        P_OFF  = 2'b11
    } pull_e;

    typedef struct packed {
        pin_mode_e        mode;
        pull_e            pull;
        logic             odrain;
        logic [1:0]       speed;
        logic [AF_W-1:0]  afsel;
        logic             odata;
    } pin_cfg_t;

    typedef struct packed {
        logic       out;
        logic       oe;
        logic       pu;
        logic       pd;
        logic       ana;
        logic [1:0] speed;
    } pad_ctl_t;

    // replicate a per-pin mask onto 2-bit fields
    function automatic logic [W2-1:0] spread2(input logic [NPINS-1:0] m);
        logic [W2-1:0] r;
        for (int i = 0; i < NPINS; i++) r[2*i +: 2] = {2{m[i]}};
        return r;
    endfunction

    // replicate a per-pin mask onto function-select fields
    function automatic logic [W4-1:0] spread4(input logic [NPINS-1:0] m);
        logic [W4-1:0] r;
        for (int i = 0; i < NPINS; i++) r[AF_W*i +: AF_W] = {AF_W{m[i]}};
        return r;
    endfunction

    // keep bits outside mask, take new bits inside mask
    function automatic logic [REG_W-1:0] merge32(input logic [REG_W-1:0] old_v,
                                                 input logic [REG_W-1:0] new_v,
                                                 input logic [REG_W-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spb_regs.sv
module spb_regs
    import spb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_en,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [REG_W-1:0]       bus_wdata,
    input  logic                   bus_sec,
    input  logic [NPINS-1:0]       in_sync,
    output logic [REG_W-1:0]       bus_rdata,
    output pin_cfg_t [NPINS-1:0]   cfg
);
    logic [W2-1:0]    mode_q, pull_q, speed_q;
    logic [NPINS-1:0] otype_q, odata_q, sec_q;
    logic [W4-1:0]    af_q;

    logic             wr_stb;
    reg_addr_e        addr;
    logic [NPINS-1:0] wr_ok, rd_ok, ana_pins, set_bits, clr_bits;
    logic [W2-1:0]    wmask2, rmask2, smask2;
    logic [W4-1:0]    wmask4, rmask4;
    logic [REG_W-1:0] raw;

    assign wr_stb   = bus_en && bus_we;
    assign addr     = reg_addr_e'(bus_addr);
    assign wr_ok    = bus_sec ? '1 : ~sec_q;
    assign rd_ok    = bus_sec ? '1 : ~sec_q;
    assign wmask2   = spread2(wr_ok);
    assign rmask2   = spread2(rd_ok);
    assign smask2   = spread2(sec_q);
    assign wmask4   = spread4(wr_ok);
    assign rmask4   = spread4(rd_ok);
    assign set_bits = bus_wdata[NPINS-1:0];
    assign clr_bits = bus_wdata[REG_W-1:NPINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '1;
            pull_q  <= '0;
            speed_q <= '0;
            otype_q <= '0;
            odata_q <= '0;
            af_q    <= '0;
            sec_q   <= '1;
        end else if (wr_stb) begin
            case (addr)
                A_MODE:   mode_q  <= merge32(mode_q, bus_wdata, wmask2);
                A_PULL:   pull_q  <= merge32(pull_q, bus_wdata, wmask2);
                A_SPEED:  speed_q <= merge32(speed_q, bus_wdata, wmask2);
                A_OTYPE:  otype_q <= (otype_q & ~wr_ok) | (bus_wdata[NPINS-1:0] & wr_ok);
                A_AFLO:   af_q[REG_W-1:0] <= merge32(af_q[REG_W-1:0], bus_wdata,
                                                     wmask4[REG_W-1:0]);
                A_AFHI:   af_q[W4-1:REG_W] <= merge32(af_q[W4-1:REG_W], bus_wdata,
                                                      wmask4[W4-1:REG_W]);
                A_ODATA:  odata_q <= (odata_q & ~wr_ok) | (bus_wdata[NPINS-1:0] & wr_ok);
                A_SETCLR: odata_q <= (odata_q & ~(clr_bits & wr_ok)) | (set_bits & wr_ok);
                A_SECM:   if (bus_sec) sec_q <= bus_wdata[NPINS-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            ana_pins[i]   = (pin_mode_e'(mode_q[2*i +: 2]) == M_ANA);
            cfg[i].mode   = pin_mode_e'(mode_q[2*i +: 2]);
            cfg[i].pull   = pull_e'(pull_q[2*i +: 2]);
            cfg[i].speed  = speed_q[2*i +: 2];
            cfg[i].odrain = otype_q[i];
            cfg[i].afsel  = af_q[AF_W*i +: AF_W];
            cfg[i].odata  = odata_q[i];
        end
    end

    always_comb begin
        raw = '0;
        case (addr)
            A_MODE:  raw = mode_q & rmask2;
            A_PULL:  raw = pull_q & rmask2;
            A_SPEED: raw = speed_q & rmask2;
            A_OTYPE: raw[NPINS-1:0] = otype_q & rd_ok;
            A_AFLO:  raw = af_q[REG_W-1:0] & rmask4[REG_W-1:0];
            A_AFHI:  raw = af_q[W4-1:REG_W] & rmask4[W4-1:REG_W];
            A_ODATA: raw[NPINS-1:0] = odata_q & rd_ok;
            A_IDATA: raw[NPINS-1:0] = in_sync & ~ana_pins & rd_ok;
            A_SECM:  raw[NPINS-1:0] = sec_q;
            default: raw = '0;
        endcase
    end

    assign bus_rdata = (bus_en && !bus_we) ? raw : '0;

    // R1: reset leaves every pin analog and secure
    assert_reset_analog_R1: assert property (@(posedge clk)
        rst |=> (mode_q == '1 && sec_q == '1 && pull_q == '0 && odata_q == '0));

    // R7: bits named in the set half are 1 after the write
    assert_set_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && bus_sec && addr == A_SETCLR) |=>
        ((odata_q & $past(set_bits)) == $past(set_bits)));

    // R9: a non-secure mode write leaves secure pins untouched
    assert_ns_write_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !bus_sec && addr == A_MODE) |=>
        (((mode_q ^ $past(mode_q)) & $past(smask2)) == '0));

    // R10: per-pin registers hide secure pins from non-secure reads
    assert_ns_read_hidden_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && !bus_sec &&
         (addr == A_ODATA || addr == A_IDATA || addr == A_OTYPE)) |->
        ((bus_rdata[NPINS-1:0] & sec_q) == '0));

    // R11: the secure mask ignores non-secure writes
    assert_mask_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !bus_sec && addr == A_SECM) |=> $stable(sec_q));

endmodule

// File: rtl/spb_pin_cell.sv
module spb_pin_cell
    import spb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_cfg_t          cfg,
    input  logic [AF_NUM-1:0] af_val,
    input  logic [AF_NUM-1:0] af_dir,
    output pad_ctl_t          pad
);
    logic want_en, want_val, digital_out;

    always_comb begin
        want_en     = 1'b0;
        want_val    = 1'b0;
        digital_out = 1'b0;
        case (cfg.mode)
            M_OUT: begin
                want_en     = 1'b1;
                want_val    = cfg.odata;
                digital_out = 1'b1;
            end
            M_AF: begin
                want_en     = af_dir[cfg.afsel];
                want_val    = af_val[cfg.afsel];
                digital_out = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        pad       = '0;
        pad.ana   = (cfg.mode == M_ANA);
        if (cfg.mode != M_ANA) begin
            pad.pu = (cfg.pull == P_UP);
            pad.pd = (cfg.pull == P_DOWN);
        end
        if (digital_out) begin
            pad.speed = cfg.speed;
            if (cfg.odrain) begin
                pad.oe  = want_en && !want_val;
                pad.out = 1'b0;
            end else begin
                pad.oe  = want_en;
                pad.out = want_en && want_val;
            end
        end
    end

    // R3: analog pins have no pulls and no driver
    assert_analog_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == M_ANA) |-> (!pad.pu && !pad.pd && !pad.oe && pad.ana));

    // R5: an open-drain pin never drives high
    assert_od_no_high_R5: assert property (@(posedge clk) disable iff (rst)
        cfg.odrain |-> !(pad.oe && pad.out));

    // R2: input pins do not drive
    assert_input_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == M_IN) |-> (!pad.oe && !pad.out));

    // R6: no slew code outside driving modes
    assert_speed_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == M_IN || cfg.mode == M_ANA) |-> (pad.speed == 2'b00));

endmodule

// File: rtl/secure_pin_bank.sv
module secure_pin_bank
    import spb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [REG_W-1:0]        bus_wdata,
    input  logic                    bus_sec,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [NPINS-1:0]        pad_in,
    output logic [NPINS-1:0]        pad_out,
    output logic [NPINS-1:0]        pad_oe,
    output logic [NPINS-1:0]        pad_pu,
    output logic [NPINS-1:0]        pad_pd,
    output logic [NPINS-1:0]        pad_ana,
    output logic [W2-1:0]           pad_speed,
    input  logic [NPINS*AF_NUM-1:0] af_val,
    input  logic [NPINS*AF_NUM-1:0] af_dir
);
    logic [NPINS-1:0]      in_sync;
    pin_cfg_t [NPINS-1:0]  cfg;
    pad_ctl_t [NPINS-1:0]  pad_ctl;

    spb_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_sync)
    );

    spb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_sec   (bus_sec),
        .in_sync   (in_sync),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        spb_pin_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg[p]),
            .af_val (af_val[p*AF_NUM +: AF_NUM]),
            .af_dir (af_dir[p*AF_NUM +: AF_NUM]),
            .pad    (pad_ctl[p])
        );
        assign pad_out[p]           = pad_ctl[p].out;
        assign pad_oe[p]            = pad_ctl[p].oe;
        assign pad_pu[p]            = pad_ctl[p].pu;
        assign pad_pd[p]            = pad_ctl[p].pd;
        assign pad_ana[p]           = pad_ctl[p].ana;
        assign pad_speed[2*p +: 2]  = pad_ctl[p].speed;
    end

endmodule

// File: tb/sim_secure_pin_bank.sv
`timescale 1ns/1ps
module sim_secure_pin_bank;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_en = 1'b0, bus_we = 1'b0, bus_sec = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  pad_in = '0;
    logic [15:0]  pad_out, pad_oe, pad_pu, pad_pd, pad_ana;
    logic [31:0]  pad_speed;
    logic [255:0] af_val = '0, af_dir = '0;

    // bench model of the register contents
    logic [31:0] m_mode, m_pull, m_speed;
    logic [15:0] m_ot, m_od, m_sec, m_in;
    logic [63:0] m_af;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    secure_pin_bank u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sec(bus_sec),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ana(pad_ana),
        .pad_speed(pad_speed), .af_val(af_val), .af_dir(af_dir)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic mdl_reset();
        m_mode = '1; m_pull = '0; m_speed = '0; m_ot = '0; m_od = '0;
        m_af = '0; m_sec = '1; m_in = '0;
    endtask

    task automatic mdl_write(input logic [3:0] a, input logic [31:0] d, input logic s);
        logic [15:0] ok;
        logic [31:0] ok2;
        logic [63:0] ok4;
        ok = s ? 16'hFFFF : ~m_sec;
        for (int i = 0; i < 16; i++) begin
            ok2[2*i +: 2] = {2{ok[i]}};
            ok4[4*i +: 4] = {4{ok[i]}};
        end
        case (a)
            4'd0: m_mode  = (m_mode & ~ok2) | (d & ok2);
            4'd1: m_pull  = (m_pull & ~ok2) | (d & ok2);
            4'd2: m_ot    = (m_ot & ~ok) | (d[15:0] & ok);
            4'd3: m_speed = (m_speed & ~ok2) | (d & ok2);
            4'd4: m_af[31:0]  = (m_af[31:0] & ~ok4[31:0]) | (d & ok4[31:0]);
            4'd5: m_af[63:32] = (m_af[63:32] & ~ok4[63:32]) | (d & ok4[63:32]);
            4'd6: m_od    = (m_od & ~ok) | (d[15:0] & ok);
            4'd7: begin
                m_od = m_od & ~(d[31:16] & ok);
                m_od = m_od | (d[15:0] & ok);
            end
            4'd9: if (s) m_sec = d[15:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic s);
        logic [15:0] ok, ana;
        logic [31:0] ok2, r;
        logic [63:0] ok4;
        ok = s ? 16'hFFFF : ~m_sec;
        for (int i = 0; i < 16; i++) begin
            ok2[2*i +: 2] = {2{ok[i]}};
            ok4[4*i +: 4] = {4{ok[i]}};
            ana[i] = (m_mode[2*i +: 2] == 2'b11);
        end
        case (a)
            4'd0: r = m_mode & ok2;
            4'd1: r = m_pull & ok2;
            4'd2: r = {16'h0, m_ot & ok};
            4'd3: r = m_speed & ok2;
            4'd4: r = m_af[31:0] & ok4[31:0];
            4'd5: r = m_af[63:32] & ok4[63:32];
            4'd6: r = {16'h0, m_od & ok};
            4'd8: r = {16'h0, m_in & ~ana & ok};
            4'd9: r = {16'h0, m_sec};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic exp_pads(output logic [15:0] o, output logic [15:0] oe,
                            output logic [15:0] pu, output logic [15:0] pd,
                            output logic [15:0] an, output logic [31:0] sp);
        for (int p = 0; p < 16; p++) begin
            logic [1:0] md;
            logic [3:0] sel;
            logic en, v, drv;
            md = m_mode[2*p +: 2];
            sel = m_af[4*p +: 4];
            en = 0; v = 0; drv = 0;
            if (md == 2'b01) begin en = 1; v = m_od[p]; drv = 1; end
            if (md == 2'b10) begin en = af_dir[p*16 + sel]; v = af_val[p*16 + sel]; drv = 1; end
            an[p] = (md == 2'b11);
            pu[p] = !an[p] && (m_pull[2*p +: 2] == 2'b01);
            pd[p] = !an[p] && (m_pull[2*p +: 2] == 2'b10);
            sp[2*p +: 2] = drv ? m_speed[2*p +: 2] : 2'b00;
            if (m_ot[p]) begin oe[p] = en && !v; o[p] = 1'b0; end
            else         begin oe[p] = en;       o[p] = en && v; end
        end
    endtask

    task automatic check_pads(input string req);
        logic [15:0] o, oe, pu, pd, an;
        logic [31:0] sp;
        exp_pads(o, oe, pu, pd, an, sp);
        chk(req, "pad_out", 64'(pad_out), 64'(o));
        chk(req, "pad_oe", 64'(pad_oe), 64'(oe));
        chk(req, "pad_pu", 64'(pad_pu), 64'(pu));
        chk(req, "pad_pd", 64'(pad_pd), 64'(pd));
        chk(req, "pad_ana", 64'(pad_ana), 64'(an));
        chk(req, "pad_speed", 64'(pad_speed), 64'(sp));
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_sec = s;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        mdl_write(a, d, s);
        #1;
    endtask

    task automatic rd(input logic [3:0] a, input logic s, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a; bus_sec = s;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [255:0] sel_mask;
        void'($urandom(32'h5EED_0042));
        mdl_reset();
        repeat (4) @(posedge clk);
        #1;
        // R1: pad state while reset is held
        chk("R1", "oe in reset", 64'(pad_oe), 64'h0);
        chk("R1", "ana in reset", 64'(pad_ana), 64'hFFFF);
        @(negedge clk) rst = 0;
        #1;
        chk("R1", "pulls after reset", 64'(pad_pu | pad_pd), 64'h0);
        check_pads("R1");
        rd(4'd0, 1, r); chk("R1", "MODE reset", 64'(r), 64'hFFFF_FFFF);
        rd(4'd9, 0, r); chk("R11", "SECMASK reset", 64'(r), 64'hFFFF);

        // R11: non-secure mask write dropped
        wr(4'd9, 32'h0, 0);
        rd(4'd9, 1, r); chk("R11", "SECMASK after ns write", 64'(r), 64'hFFFF);

        // R9/R10 with all pins secure
        wr(4'd0, 32'h0, 0);
        rd(4'd0, 1, r); chk("R9", "MODE after ns write", 64'(r), 64'hFFFF_FFFF);
        rd(4'd0, 0, r); chk("R10", "MODE ns read", 64'(r), 64'h0);

        // split mask: pins 0-7 secure
        wr(4'd9, 32'h0000_00FF, 1);
        wr(4'd0, 32'h0, 0);
        rd(4'd0, 1, r); chk("R9", "MODE split", 64'(r), 64'h0000_FFFF);
        chk("R9", "ana split", 64'(pad_ana), 64'h00FF);
        wr(4'd6, 32'hFFFF, 1);
        rd(4'd6, 0, r); chk("R10", "ODATA ns read", 64'(r), 64'hFF00);
        rd(4'd6, 1, r); chk("R10", "ODATA s read", 64'(r), 64'hFFFF);

        // R2/R7 output and set/clear
        wr(4'd9, 32'h0, 1);
        wr(4'd0, 32'h5555_5555, 0);
        wr(4'd2, 32'h0, 0);
        wr(4'd6, 32'h0000_00F0, 0);
        wr(4'd7, 32'h0030_0F01, 0);
        chk("R7", "pad_out after setclr", 64'(pad_out), 64'h0FC1);
        chk("R2", "oe in output mode", 64'(pad_oe), 64'hFFFF);
        wr(4'd7, 32'h0001_0001, 0);
        rd(4'd6, 0, r); chk("R7", "set wins", 64'(r), 64'h0FC1);
        rd(4'd7, 1, r); chk("R7", "SETCLR reads zero", 64'(r), 64'h0);

        // R5 open-drain
        wr(4'd2, 32'hFFFF, 0);
        chk("R5", "od oe", 64'(pad_oe), 64'hF03E);
        chk("R5", "od out", 64'(pad_out), 64'h0);

        // R3 pulls
        wr(4'd1, 32'h9999_9999, 0);
        wr(4'd0, 32'h0, 0);
        chk("R3", "pu input", 64'(pad_pu), 64'h5555);
        chk("R3", "pd input", 64'(pad_pd), 64'hAAAA);
        wr(4'd0, 32'hFFFF_FFFF, 0);
        chk("R3", "pulls analog", 64'(pad_pu | pad_pd), 64'h0);
        rd(4'd1, 0, r); chk("R3", "PULL kept", 64'(r), 64'h9999_9999);

        // R6 speed
        wr(4'd3, 32'hE4E4_E4E4, 0);
        chk("R6", "speed analog", 64'(pad_speed), 64'h0);
        wr(4'd0, 32'h5555_5555, 0);
        chk("R6", "speed output", 64'(pad_speed), 64'hE4E4_E4E4);

        // R4 alternate functions: pin p selects line p
        wr(4'd2, 32'h0, 0);
        wr(4'd0, 32'hAAAA_AAAA, 0);
        wr(4'd4, 32'h7654_3210, 0);
        wr(4'd5, 32'hFEDC_BA98, 0);
        sel_mask = '0;
        for (int p = 0; p < 16; p += 2) sel_mask[p*16 + p] = 1'b1;
        af_dir = '1; af_val = sel_mask;
        #1;
        chk("R4", "af out even", 64'(pad_out), 64'h5555);
        chk("R4", "af oe", 64'(pad_oe), 64'hFFFF);
        af_val = ~sel_mask;
        #1;
        chk("R4", "af out odd", 64'(pad_out), 64'hAAAA);
        check_pads("R4");
        wr(4'd6, 32'h0, 0);
        wr(4'd0, 32'h5555_5555, 0);
        af_val = '1;
        #1;
        chk("R4", "af ignored in output", 64'(pad_out), 64'h0);

        // R8 synchroniser latency
        wr(4'd0, 32'h0, 0);
        repeat (3) @(negedge clk);
        pad_in = 16'hA5C3;
        rd(4'd8, 1, r); chk("R8", "one edge", 64'(r), 64'h0);
        rd(4'd8, 1, r); chk("R8", "two edges", 64'(r), 64'hA5C3);
        m_in = 16'hA5C3;
        wr(4'd0, 32'h0000_0003, 1);
        rd(4'd8, 1, r); chk("R8", "analog pin reads 0", 64'(r), 64'hA5C2);

        // random phase
        for (int it = 0; it < 400; it++) begin
            logic [3:0]  a;
            logic [31:0] d;
            logic        s;
            logic [31:0] got;
            af_val = {8{$urandom}};
            af_dir = {8{$urandom}};
            pad_in = $urandom;
            a = 4'($urandom % 16);
            d = $urandom;
            s = (($urandom % 4) != 0);
            if (($urandom % 8) == 0) a = 4'd9;
            wr(a, d, s);
            @(negedge clk);
            m_in = pad_in;
            #1;
            check_pads("R2-mix");
            a = 4'($urandom % 16);
            s = $urandom % 2;
            rd(a, s, got);
            chk(s ? "R9" : "R10", "random readback", 64'(got), 64'(exp_read(a, s)));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule